// File: doc/BRIEF.md
# Stored register bank controller

This block keeps a small bank of persistent setting registers, four entries of six bits by default, and sits between a serial bus slave and the wiper register of a digitally controlled potentiometer. The slave hands it store requests. A request either carries a byte from the host or asks for a copy of the wiper's present position. The request is held as pending until the slave reports the stop condition that closes the bus command. Only then does the block check the write-protect pin. If the pin allows the store, a busy window opens for a programmable number of clock cycles, and that window stands in for the memory programming time. The new value lands in its entry at the end of the window.

Reads are served whenever no store is running, with the data returned on the next cycle. After a power-on reset, the block offers entry 0 once to the wiper so the wiper register can be loaded with it. A soft reset drops pending and running stores and leaves the stored contents as they are. A power-on reset returns every entry to its parameter image.

Write requests, reads and the power-up hand-off use valid/ready. A write request, or a read, that is offered while ready is low is dropped and never queued, so the slave must not expect it to complete later. The read response has no back-pressure: it is valid for exactly one cycle. The power-up offer holds valid and its data until ready is seen.

Top module: `srb_bank_ctl`

## Requirements
- R1: After a power-on reset (por_n low), busy is 0, wr_ready is 1 and every entry reads back its slice of INIT_IMAGE. Entry i occupies bits [6i+5:6i].
- R2: After a power-on reset, recall_valid is 1 and recall_data equals entry 0. Both hold until a cycle with recall_ready high, after which recall_valid stays 0 until the next power-on reset. A soft reset does not raise it again.
- R3: A write accepted through wr_valid/wr_ready changes nothing that can be observed (no busy, no entry changed) until bus_stop is seen.
- R4: A bus_stop cycle with a pending request and wp_n high raises busy on the next cycle. Busy then stays high for exactly STORE_CYCLES cycles.
- R5: The stored value becomes readable once busy falls, and only the entry selected by wr_idx changes.
- R6: With wr_src = 1 the stored value is wiper_in as sampled in the acceptance cycle. With wr_src = 0 it is wr_data.
- R7: A bus_stop with wp_n low discards the pending request: no busy, and no entry changes.
- R8: wr_ready is 0 while busy is high. A request offered then is dropped and a later bus_stop starts nothing.
- R9: rd_ready is 0 while busy is high. An accepted read gives rd_resp_valid one cycle later, with the selected entry in rd_resp_data.
- R10: A soft reset (soft_rst_n low) ends busy on the next cycle, aborts the running store, discards any pending request and keeps all stored contents.
- R11: A second request accepted before bus_stop replaces the first, so only the last one is stored.
- R12: A bus_stop with no pending request does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; reloads the image |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous; contents kept |
| wp_n | input | 1 | Store enable; low blocks stores |
| bus_stop | input | 1 | One-cycle pulse when the bus command ends |
| wr_valid | input | 1 | Store request offered |
| wr_ready | output | 1 | Store request can be taken |
| wr_src | input | 1 | 0 = host data, 1 = wiper copy |
| wr_idx | input | 2 | Target entry |
| wr_data | input | 6 | Host data |
| wiper_in | input | 6 | Current wiper position |
| rd_valid | input | 1 | Read offered |
| rd_ready | output | 1 | Read can be taken |
| rd_idx | input | 2 | Entry to read |
| rd_resp_valid | output | 1 | Read data valid (one cycle) |
| rd_resp_data | output | 6 | Read data |
| recall_valid | output | 1 | Power-up value for the wiper offered |
| recall_ready | input | 1 | Wiper has taken the power-up value |
| recall_data | output | 6 | Entry 0 |
| busy | output | 1 | Store in progress |

## Verification
A wrong busy counter shows up as a busy window that ends too early or too late, and it is visible on the busy pin within STORE_CYCLES cycles of the stop. A pending flag that is lost or left stuck shows as a store that never starts, or as a busy window after a protected or empty stop; either one appears on the cycle after bus_stop. A staged value or index that is corrupted stays hidden until the first read after busy falls, so every store is followed by a read of all four entries. A store leaking through soft reset or write protection appears the same way.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;
  typedef enum logic {
    SRC_HOST  = 1'b0,
    SRC_WIPER = 1'b1
  } srb_src_e;
endpackage

// File: rtl/srb_store_timer.sv
`timescale 1ns/1ps
// Busy window generator: opens on launch, stays open CYCLES cycles.
module srb_store_timer #(
  parameter int CYCLES = 50000
) (
  input  logic clk,
  input  logic por_n,
  input  logic soft_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (!soft_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (launch && !busy) begin
      busy   <= 1'b1;
      left_q <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  // Last busy cycle: the commit happens at this edge.
  assign done = busy && (left_q == '0) && soft_n;
endmodule

// File: rtl/srb_write_ctl.sv
`timescale 1ns/1ps
// Holds one pending store request; launches or drops it at the stop.
module srb_write_ctl #(
  parameter int W     = 6,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_n,
  input  logic             wr_valid,
  input  logic             wr_src,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [W-1:0]     wiper_in,
  input  logic             bus_stop,
  input  logic             wp_n,
  input  logic             busy,
  output logic             wr_ready,
  output logic             launch,
  output logic [IDX_W-1:0] stage_idx,
  output logic [W-1:0]     stage_data
);
  import srb_pkg::*;

  logic             pend_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     data_q;
  logic             take;
  logic [W-1:0]     pick;

  assign wr_ready = !busy && !bus_stop;
  assign take     = wr_valid && wr_ready;
  assign pick     = (srb_src_e'(wr_src) == SRC_WIPER) ? wiper_in : wr_data;
  assign launch   = bus_stop && pend_q && wp_n && !busy;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (!soft_n) begin
      pend_q <= 1'b0;
    end else if (take) begin
      pend_q <= 1'b1;
      idx_q  <= wr_idx;
      data_q <= pick;
    end else if (bus_stop) begin
      // Either launched or discarded by protection.
      pend_q <= 1'b0;
    end
  end

  // Staging stays stable through busy because wr_ready is low.
  assign stage_idx  = idx_q;
  assign stage_data = data_q;
endmodule

// File: rtl/srb_cell_bank.sv
`timescale 1ns/1ps
// Persistent entries: only por_n reloads them; soft reset never touches them.
module srb_cell_bank #(
  parameter int                    REGS  = 4,
  parameter int                    W     = 6,
  parameter int                    IDX_W = 2,
  parameter logic [REGS*W-1:0]     INIT  = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rdata,
  output logic [W-1:0]     slot0
);
  logic [REGS*W-1:0] flat;

  for (genvar g = 0; g < REGS; g++) begin : g_cell
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                          q <= INIT[g*W +: W];
      else if (we && (widx == IDX_W'(g)))  q <= wdata;
    end
    assign flat[g*W +: W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < REGS; i++) begin
      if (ridx == IDX_W'(i)) rdata = flat[i*W +: W];
    end
  end

  assign slot0 = flat[W-1:0];
endmodule

// File: rtl/srb_bank_ctl.sv
`timescale 1ns/1ps
module srb_bank_ctl #(
  parameter int                       REGS         = 4,
  parameter int                       WIDTH        = 6,
  parameter int                       STORE_CYCLES = 50000,
  parameter logic [REGS*WIDTH-1:0]    INIT_IMAGE   = '0,
  localparam int                      IDX_W        = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_rst_n,
  input  logic             wp_n,
  input  logic             bus_stop,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_src,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wiper_in,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_resp_valid,
  output logic [WIDTH-1:0] rd_resp_data,
  output logic             recall_valid,
  input  logic             recall_ready,
  output logic [WIDTH-1:0] recall_data,
  output logic             busy
);
  logic             launch;
  logic             done;
  logic [IDX_W-1:0] stage_idx;
  logic [WIDTH-1:0] stage_data;
  logic [WIDTH-1:0] bank_rdata;
  logic [WIDTH-1:0] bank_slot0;
  logic             recall_q;

  srb_write_ctl #(.W(WIDTH), .IDX_W(IDX_W)) u_wctl (
    .clk        (clk),
    .por_n      (por_n),
    .soft_n     (soft_rst_n),
    .wr_valid   (wr_valid),
    .wr_src     (wr_src),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .wiper_in   (wiper_in),
    .bus_stop   (bus_stop),
    .wp_n       (wp_n),
    .busy       (busy),
    .wr_ready   (wr_ready),
    .launch     (launch),
    .stage_idx  (stage_idx),
    .stage_data (stage_data)
  );

  srb_store_timer #(.CYCLES(STORE_CYCLES)) u_timer (
    .clk    (clk),
    .por_n  (por_n),
    .soft_n (soft_rst_n),
    .launch (launch),
    .busy   (busy),
    .done   (done)
  );

  srb_cell_bank #(.REGS(REGS), .W(WIDTH), .IDX_W(IDX_W), .INIT(INIT_IMAGE)) u_bank (
    .clk   (clk),
    .por_n (por_n),
    .we    (done),
    .widx  (stage_idx),
    .wdata (stage_data),
    .ridx  (rd_idx),
    .rdata (bank_rdata),
    .slot0 (bank_slot0)
  );

  assign rd_ready = !busy;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      rd_resp_valid <= rd_valid && rd_ready;
      if (rd_valid && rd_ready) rd_resp_data <= bank_rdata;
    end
  end

  // One-shot power-up hand-off of entry 0 to the wiper.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            recall_q <= 1'b1;
    else if (recall_ready) recall_q <= 1'b0;
  end

  assign recall_valid = recall_q;
  assign recall_data  = bank_slot0;
endmodule

// File: rtl/srb_bank_checker.sv
`timescale 1ns/1ps
module srb_bank_checker #(
  parameter int STORE_CYCLES = 50000
) (
  input logic clk,
  input logic por_n,
  input logic soft_rst_n,
  input logic wp_n,
  input logic bus_stop,
  input logic busy,
  input logic rd_valid,
  input logic rd_ready,
  input logic rd_resp_valid,
  input logic recall_valid,
  input logic recall_ready
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= '0;
  end

  // R4: a window that ends without soft reset lasted exactly STORE_CYCLES.
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!busy && run_q != 0 && $past(soft_rst_n)) |-> run_q == 32'(STORE_CYCLES));

  // R4: never longer than STORE_CYCLES.
  p_busy_max_r4: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> run_q < 32'(STORE_CYCLES));

  // R3: busy only rises after an enabled stop.
  p_start_after_stop_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> $past(bus_stop && wp_n));

  // R7: a protected stop while idle leaves the block idle.
  p_protect_r7: assert property (@(posedge clk) disable iff (!por_n)
    (bus_stop && !wp_n && !busy) |=> !busy);

  // R9: an accepted read answers on the next cycle.
  p_read_resp_r9: assert property (@(posedge clk) disable iff (!por_n)
    (rd_valid && rd_ready) |=> rd_resp_valid);

  // R2: the power-up offer holds until taken.
  p_recall_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
    (recall_valid && !recall_ready) |=> recall_valid);

  // R2: once withdrawn, the offer never returns.
  p_recall_once_r2: assert property (@(posedge clk) disable iff (!por_n)
    !recall_valid |=> !recall_valid);

  // R10: soft reset ends busy.
  p_soft_abort_r10: assert property (@(posedge clk) disable iff (!por_n)
    !soft_rst_n |=> !busy);
endmodule

bind srb_bank_ctl srb_bank_checker #(.STORE_CYCLES(STORE_CYCLES)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .soft_rst_n    (soft_rst_n),
  .wp_n          (wp_n),
  .bus_stop      (bus_stop),
  .busy          (busy),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .rd_resp_valid (rd_resp_valid),
  .recall_valid  (recall_valid),
  .recall_ready  (recall_ready)
);

// File: tb/tb_srb_bank_ctl.sv
`timescale 1ns/1ps
module tb_srb_bank_ctl;
  localparam int          N    = 20;
  localparam logic [23:0] INIT = {6'h01, 6'h3F, 6'h15, 6'h2A};

  // {src, idx[1:0], data[5:0], wiper[5:0], wp_n}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 2'd1, 6'h0C, 6'h00, 1'b1},
    {1'b1, 2'd2, 6'h00, 6'h33, 1'b1},
    {1'b0, 2'd0, 6'h3F, 6'h00, 1'b0},
    {1'b0, 2'd3, 6'h00, 6'h00, 1'b1},
    {1'b1, 2'd0, 6'h11, 6'h07, 1'b1},
    {1'b1, 2'd3, 6'h00, 6'h3F, 1'b0},
    {1'b0, 2'd2, 6'h2A, 6'h00, 1'b1},
    {1'b0, 2'd1, 6'h3F, 6'h15, 1'b1}
  };

  logic       clk = 1'b0;
  logic       por_n = 1'b0, soft_rst_n = 1'b1, wp_n = 1'b1, bus_stop = 1'b0;
  logic       wr_valid = 1'b0, wr_src = 1'b0, rd_valid = 1'b0, recall_ready = 1'b0;
  logic [1:0] wr_idx = '0, rd_idx = '0;
  logic [5:0] wr_data = '0, wiper_in = '0;
  logic       wr_ready, rd_ready, rd_resp_valid, recall_valid, busy;
  logic [5:0] rd_resp_data, recall_data;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [5:0] model [4];

  always #2.5 clk = ~clk;

  srb_bank_ctl #(.REGS(4), .WIDTH(6), .STORE_CYCLES(N), .INIT_IMAGE(INIT)) dut (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .wp_n(wp_n), .bus_stop(bus_stop),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_src(wr_src), .wr_idx(wr_idx),
    .wr_data(wr_data), .wiper_in(wiper_in), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_idx(rd_idx), .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .recall_valid(recall_valid), .recall_ready(recall_ready), .recall_data(recall_data),
    .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic do_write(input logic src, input logic [1:0] idx, input logic [5:0] d,
                          input logic [5:0] w, output logic acc);
    @(negedge clk);
    wr_valid = 1'b1; wr_src = src; wr_idx = idx; wr_data = d; wiper_in = w;
    acc = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
    wiper_in = ~w;  // R6: later wiper motion must not matter
  endtask

  task automatic do_stop(input logic wp);
    @(negedge clk);
    bus_stop = 1'b1; wp_n = wp;
    @(negedge clk);
    bus_stop = 1'b0; wp_n = 1'b1;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 10 * N) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [1:0] idx, input logic [5:0] exp, input string tag);
    @(negedge clk);
    rd_valid = 1'b1; rd_idx = idx;
    @(negedge clk);
    rd_valid = 1'b0;
    chk({tag, " resp_valid"}, 32'(rd_resp_valid), 32'd1);
    chk({tag, " data"}, 32'(rd_resp_data), 32'(exp));
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 4; i++) do_read(2'(i), model[i], tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic acc;
    int   nb;
    for (int i = 0; i < 4; i++) model[i] = INIT[i*6 +: 6];

    // Reset state (R1, R2)
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after por", 32'(busy), 32'd0);
    chk("R1 wr_ready after por", 32'(wr_ready), 32'd1);
    chk("R2 recall_valid after por", 32'(recall_valid), 32'd1);
    chk("R2 recall_data", 32'(recall_data), 32'h2A);
    repeat (3) @(negedge clk);
    chk("R2 recall held", 32'(recall_valid), 32'd1);
    recall_ready = 1'b1;
    @(negedge clk);
    recall_ready = 1'b0;
    chk("R2 recall taken", 32'(recall_valid), 32'd0);
    read_all("R1 image");

    // R12: empty stop
    do_stop(1'b1);
    chk("R12 empty stop busy", 32'(busy), 32'd0);

    // Vector table (R3 R4 R5 R6 R7)
    for (int v = 0; v < 8; v++) begin
      logic       s, p;
      logic [1:0] ix;
      logic [5:0] d, w;
      {s, ix, d, w, p} = VEC[v];
      do_write(s, ix, d, w, acc);
      chk("R3 accepted", 32'(acc), 32'd1);
      chk("R3 no busy before stop", 32'(busy), 32'd0);
      do_read(ix, model[ix], "R3 unchanged before stop");
      do_stop(p);
      count_busy(nb);
      chk(p ? "R4 busy length" : "R7 protected no busy", 32'(nb), p ? 32'(N) : 32'd0);
      if (p) model[ix] = s ? w : d;
      read_all(s ? "R6 wiper copy" : "R5 host store");
    end

    // R11: last request wins
    do_write(1'b0, 2'd2, 6'h05, 6'h00, acc);
    do_write(1'b0, 2'd0, 6'h06, 6'h00, acc);
    do_stop(1'b1);
    count_busy(nb);
    chk("R11 busy length", 32'(nb), 32'(N));
    model[0] = 6'h06;
    read_all("R11 last wins");

    // R8, R9: requests while busy
    do_write(1'b0, 2'd3, 6'h12, 6'h00, acc);
    do_stop(1'b1);
    do_write(1'b0, 2'd3, 6'h2F, 6'h00, acc);
    chk("R8 wr_ready while busy", 32'(acc), 32'd0);
    @(negedge clk);
    rd_valid = 1'b1; rd_idx = 2'd1;
    chk("R9 rd_ready while busy", 32'(rd_ready), 32'd0);
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R9 no resp while busy", 32'(rd_resp_valid), 32'd0);
    count_busy(nb);
    model[3] = 6'h12;
    do_stop(1'b1);
    chk("R8 dropped request not queued", 32'(busy), 32'd0);
    read_all("R8 after busy");

    // R10: soft reset aborts a running store and drops pending
    do_write(1'b0, 2'd1, 6'h2B, 6'h00, acc);
    do_stop(1'b1);
    repeat (3) @(negedge clk);
    soft_rst_n = 1'b0;
    @(negedge clk);
    soft_rst_n = 1'b1;
    chk("R10 busy cleared", 32'(busy), 32'd0);
    chk("R10 no recall", 32'(recall_valid), 32'd0);
    do_write(1'b0, 2'd2, 6'h3A, 6'h00, acc);
    @(negedge clk);
    soft_rst_n = 1'b0;
    @(negedge clk);
    soft_rst_n = 1'b1;
    do_stop(1'b1);
    chk("R10 pending dropped", 32'(busy), 32'd0);
    read_all("R10 contents kept");

    // R1: power-on reset restores the image
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) model[i] = INIT[i*6 +: 6];
    chk("R2 recall after second por", 32'(recall_valid), 32'd1);
    chk("R2 recall data after por", 32'(recall_data), 32'h2A);
    read_all("R1 image after por");

    summary();
  end
endmodule